// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a fully associative address translation buffer with a parameterised number of entries. Each entry describes two neighbouring virtual pages, an even page and an odd page, that share one virtual tag, one address-space ID and one page-size mask. Each of the two pages has its own physical frame number, a valid bit, a dirty (writable) bit, a 3-bit cache attribute, an execute-inhibit bit and a read-inhibit bit.

Software-style maintenance goes through a set of staging words: a high word (virtual tag, invalidate bit, address-space ID), a mask word, and two low words, one for each half. A one-cycle command input loads an entry from the staging words at a given index or at a supplied pseudo-random index. It can also probe for the entry that matches the staging high word, read an entry back into output registers, invalidate every non-global entry of one address-space ID, or invalidate the whole buffer. A separate translate port takes a virtual address, an access type and the current address-space ID. One cycle later it returns a physical address with a permission set, or a fault code.

Commands are applied on `cmd_op`: 0 idle, 1 indexed write, 2 random-index write, 3 probe, 4 indexed read, 5 selective invalidate, 6 full invalidate. Access types on `xl_type` are 0 load, 1 store, 2 instruction fetch; code 3 is treated as a load.

Top module: `paired_tlb`

## Requirements
- R1: After reset every entry is invalid. A translation returns code 1 (no match) with zero address and zero permissions, and a probe returns 32'h8000_0000. `probe_index` and the read registers reset to zero.
- R2: An entry matches only when all three hold: its stored tag and the looked-up tag (address bits 31:13) are equal once both are ANDed with the inverse of the entry's mask; its global bit is set or its address-space ID equals the looked-up one; its invalidate flag is clear.
- R3: Staging encoding. High word: tag in bits 31:13, invalidate in bit 10, address-space ID in bits 7:0. Low words: global bit 0, valid bit 1, dirty bit 2, cache attribute bits 5:3, frame number bits 25:6, execute-inhibit bit 26, read-inhibit bit 27. The stored global bit is the AND of bit 0 of the two low words. A frame number is stored with its bits cleared wherever the mask word is set.
- R4: Indexed write (1) and indexed read (4) choose the entry as (`cmd_index` with bit 31 cleared) modulo the entry count. Random write (2) applies the same rule to `rand_index`.
- R5: A probe (3) updates `probe_index` one cycle later. On a hit it holds the lowest matching index with bit 31 clear. On a miss it holds exactly 32'h8000_0000. The lookup uses the tag and address-space ID of the staging high word.
- R6: A write whose staging high word has bit 10 set only marks the entry invalid; the other staging fields are ignored. Reading an invalid entry returns a high word of 32'h400 and zero mask and low words.
- R7: Translation selects the odd half when the address bit just above the entry's page offset is set (bit 12 plus the number of mask bits set). The physical address is the selected frame number shifted left by 12, ORed with the address bits below that selector bit. With several matches the lowest index is used.
- R8: Fault codes are checked in this order: valid clear gives 2; fetch with execute-inhibit set gives 3; load with read-inhibit set gives 4; store with dirty clear gives 5; otherwise code 0.
- R9: On code 0 the permissions are bit 0 read (always), bit 1 write (dirty set), bit 2 execute (execute-inhibit clear). Any non-zero code gives zero address and zero permissions. `xl_valid` and the result follow `xl_req` by one cycle.
- R10: Selective invalidate (5) marks invalid every entry whose global bit is clear and whose address-space ID equals bits 7:0 of the staging high word. Global entries and other IDs keep matching.
- R11: Full invalidate (6) marks every entry invalid, global ones included.
- R12: A read (4) of a valid entry returns its tag and ID in the high word, its mask, and both low words with the stored global bit in bit 0 of each.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Maintenance command, 0 idle |
| cmd_index | input | 32 | Index for indexed write and read |
| rand_index | input | 32 | Index for random write |
| stg_hi | input | VA_W | Staging high word |
| stg_mask | input | VA_W-13 | Staging page mask |
| stg_lo0 | input | PFN_W+8 | Staging low word, even page |
| stg_lo1 | input | PFN_W+8 | Staging low word, odd page |
| probe_index | output | 32 | Probe result |
| rd_hi | output | VA_W | Read-back high word |
| rd_mask | output | VA_W-13 | Read-back mask |
| rd_lo0 | output | PFN_W+8 | Read-back even low word |
| rd_lo1 | output | PFN_W+8 | Read-back odd low word |
| xl_req | input | 1 | Translate request |
| xl_va | input | VA_W | Virtual address |
| xl_type | input | 2 | Access type |
| cur_asid | input | ASID_W | Current address-space ID |
| xl_valid | output | 1 | Translate result valid |
| xl_pa | output | PFN_W+12 | Physical address |
| xl_code | output | 3 | Result or fault code |
| xl_perm | output | 3 | Permissions {exec, write, read} |

## Verification
A corrupted entry field shows up at the translate port on the very next request that hits it. A wrong frame bit gives a wrong address, a wrong valid, dirty or inhibit bit gives a wrong code or permission, and a wrong tag, ID or invalidate flag turns a hit into no-match or the reverse. Fields that translation never exposes, the cache attribute and the raw stored words, only appear through a read command, one cycle after it is issued. Because the lowest index wins, a stale duplicate entry stays hidden until the lower copy is invalidated, so the stimulus writes duplicates on purpose and removes them in sequence.

// File: rtl/paired_tlb.sv
module paired_tlb #(
  parameter int NENT   = 8,
  parameter int VA_W   = 32,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8,
  localparam int MW    = VA_W - 13,
  localparam int LO_W  = PFN_W + 8,
  localparam int PA_W  = PFN_W + 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [31:0]       cmd_index,
  input  logic [31:0]       rand_index,
  input  logic [VA_W-1:0]   stg_hi,
  input  logic [MW-1:0]     stg_mask,
  input  logic [LO_W-1:0]   stg_lo0,
  input  logic [LO_W-1:0]   stg_lo1,
  output logic [31:0]       probe_index,
  output logic [VA_W-1:0]   rd_hi,
  output logic [MW-1:0]     rd_mask,
  output logic [LO_W-1:0]   rd_lo0,
  output logic [LO_W-1:0]   rd_lo1,
  input  logic              xl_req,
  input  logic [VA_W-1:0]   xl_va,
  input  logic [1:0]        xl_type,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              xl_valid,
  output logic [PA_W-1:0]   xl_pa,
  output logic [2:0]        xl_code,
  output logic [2:0]        xl_perm
);
  localparam int IDX_W   = (NENT > 1) ? $clog2(NENT) : 1;
  localparam int INV_BIT = 10;
  localparam int XI_BIT  = PFN_W + 6;
  localparam int RI_BIT  = PFN_W + 7;

  localparam logic [2:0] OP_WR_IDX = 3'd1, OP_WR_RND = 3'd2, OP_PROBE = 3'd3,
                         OP_READ = 3'd4, OP_INV_SEL = 3'd5, OP_INV_ALL = 3'd6;
  localparam logic [2:0] C_OK = 3'd0, C_NOMATCH = 3'd1, C_INVALID = 3'd2,
                         C_XI = 3'd3, C_RI = 3'd4, C_DIRTY = 3'd5;

  logic [MW-1:0]     e_vpn  [NENT];
  logic [MW-1:0]     e_mask [NENT];
  logic [ASID_W-1:0] e_asid [NENT];
  logic [LO_W-1:0]   e_lo0  [NENT];
  logic [LO_W-1:0]   e_lo1  [NENT];
  logic [NENT-1:0]   e_g, e_inv;

  logic [NENT-1:0]   pr_hit, xl_hit;
  logic [MW-1:0]     pr_vpn, xl_vpn;
  logic [ASID_W-1:0] stg_asid;
  logic [31:0]       slot_src;
  logic [IDX_W-1:0]  slot;
  logic              unused_hi;

  assign pr_vpn    = stg_hi[VA_W-1:13];
  assign xl_vpn    = xl_va[VA_W-1:13];
  assign stg_asid  = stg_hi[ASID_W-1:0];
  assign slot_src  = (cmd_op == OP_WR_RND) ? rand_index : cmd_index;
  assign slot      = IDX_W'((slot_src & 32'h7FFF_FFFF) % 32'(NENT));
  assign unused_hi = ^stg_hi;

  for (genvar i = 0; i < NENT; i++) begin : g_match
    assign pr_hit[i] = ((e_vpn[i] & ~e_mask[i]) == (pr_vpn & ~e_mask[i])) &&
                       (e_g[i] || e_asid[i] == stg_asid) && !e_inv[i];
    assign xl_hit[i] = ((e_vpn[i] & ~e_mask[i]) == (xl_vpn & ~e_mask[i])) &&
                       (e_g[i] || e_asid[i] == cur_asid) && !e_inv[i];
  end

  logic             pr_any, xl_any;
  logic [IDX_W-1:0] pr_sel, xl_sel;

  always_comb begin
    pr_any = 1'b0; pr_sel = '0;
    xl_any = 1'b0; xl_sel = '0;
    for (int i = NENT - 1; i >= 0; i--) begin
      if (pr_hit[i]) begin pr_any = 1'b1; pr_sel = IDX_W'(i); end
      if (xl_hit[i]) begin xl_any = 1'b1; xl_sel = IDX_W'(i); end
    end
  end

  logic [VA_W-1:0] full_mask;
  logic            odd;
  logic [LO_W-1:0] half;
  logic            unused_half;
  logic [PA_W-1:0] n_pa;
  logic [2:0]      n_code, n_perm;

  assign full_mask   = {e_mask[xl_sel], 13'h1FFF};
  assign odd         = |(xl_va & full_mask & ~(full_mask >> 1));
  assign half        = odd ? e_lo1[xl_sel] : e_lo0[xl_sel];
  assign unused_half = ^{half[5:3], half[0]};

  always_comb begin
    n_pa   = '0;
    n_perm = '0;
    if (!xl_any)                          n_code = C_NOMATCH;
    else if (!half[1])                    n_code = C_INVALID;
    else if (xl_type == 2'd2 && half[XI_BIT]) n_code = C_XI;
    else if ((xl_type == 2'd0 || xl_type == 2'd3) && half[RI_BIT]) n_code = C_RI;
    else if (xl_type == 2'd1 && !half[2]) n_code = C_DIRTY;
    else begin
      n_code = C_OK;
      n_pa   = {half[6 +: PFN_W], 12'h000} | PA_W'(xl_va & (full_mask >> 1));
      n_perm = {!half[XI_BIT], half[2], 1'b1};
    end
  end

  function automatic logic [LO_W-1:0] pack_lo(input logic [LO_W-1:0] lo,
                                               input logic [MW-1:0] m);
    logic [LO_W-1:0] r;
    r            = lo;
    r[0]         = 1'b0;
    r[6 +: PFN_W] = lo[6 +: PFN_W] & ~PFN_W'(m);
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NENT; i++) begin
        e_vpn[i]  <= '0;
        e_mask[i] <= '0;
        e_asid[i] <= '0;
        e_lo0[i]  <= '0;
        e_lo1[i]  <= '0;
      end
      e_g         <= '0;
      e_inv       <= '1;
      probe_index <= '0;
      rd_hi       <= '0;
      rd_mask     <= '0;
      rd_lo0      <= '0;
      rd_lo1      <= '0;
      xl_valid    <= 1'b0;
      xl_pa       <= '0;
      xl_code     <= '0;
      xl_perm     <= '0;
    end else begin
      xl_valid <= xl_req;
      if (xl_req) begin
        xl_pa   <= n_pa;
        xl_code <= n_code;
        xl_perm <= n_perm;
      end
      case (cmd_op)
        OP_WR_IDX, OP_WR_RND: begin
          for (int i = 0; i < NENT; i++) begin
            if (slot == IDX_W'(i)) begin
              if (stg_hi[INV_BIT]) begin
                e_inv[i] <= 1'b1;
              end else begin
                e_inv[i]  <= 1'b0;
                e_vpn[i]  <= pr_vpn;
                e_asid[i] <= stg_asid;
                e_mask[i] <= stg_mask;
                e_g[i]    <= stg_lo0[0] & stg_lo1[0];
                e_lo0[i]  <= pack_lo(stg_lo0, stg_mask);
                e_lo1[i]  <= pack_lo(stg_lo1, stg_mask);
              end
            end
          end
        end
        OP_PROBE: probe_index <= pr_any ? 32'(pr_sel) : 32'h8000_0000;
        OP_READ: begin
          if (e_inv[slot]) begin
            rd_hi   <= VA_W'(1) << INV_BIT;
            rd_mask <= '0;
            rd_lo0  <= '0;
            rd_lo1  <= '0;
          end else begin
            rd_hi   <= {e_vpn[slot], 13'h0000} | VA_W'(e_asid[slot]);
            rd_mask <= e_mask[slot];
            rd_lo0  <= e_lo0[slot] | LO_W'(e_g[slot]);
            rd_lo1  <= e_lo1[slot] | LO_W'(e_g[slot]);
          end
        end
        OP_INV_SEL: begin
          for (int i = 0; i < NENT; i++)
            if (!e_g[i] && e_asid[i] == stg_asid) e_inv[i] <= 1'b1;
        end
        OP_INV_ALL: e_inv <= '1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/paired_tlb_chk.sv
module paired_tlb_chk #(
  parameter int NENT  = 8,
  parameter int PA_W  = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            xl_req,
  input logic [1:0]      xl_type,
  input logic            xl_valid,
  input logic [PA_W-1:0] xl_pa,
  input logic [2:0]      xl_code,
  input logic [2:0]      xl_perm,
  input logic [31:0]     probe_index
);
  assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xl_req |=> xl_valid);

  assert_no_spurious_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !xl_req |=> !xl_valid);

  assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xl_valid |-> xl_code <= 3'd5);

  assert_read_always_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_code == 3'd0) |-> xl_perm[0]);

  assert_store_writable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && xl_type == 2'd1) |=> (xl_code != 3'd0 || xl_perm[1]));

  assert_fetch_executable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_req && xl_type == 2'd2) |=> (xl_code != 3'd0 || xl_perm[2]));

  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (xl_valid && xl_code != 3'd0) |-> (xl_perm == 3'd0 && xl_pa == '0));

  assert_miss_form_R5: assert property (@(posedge clk) disable iff (!rst_n)
    probe_index[31] |-> probe_index[30:0] == 31'd0);

  assert_hit_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !probe_index[31] |-> probe_index < 32'(NENT));
endmodule

bind paired_tlb paired_tlb_chk #(.NENT(NENT), .PA_W(PA_W)) u_chk (.*);

// File: tb/paired_tlb_bench.sv
module paired_tlb_bench;
  localparam int NENT = 8, VA_W = 32, PFN_W = 20, ASID_W = 8;
  localparam int MW = VA_W - 13, LO_W = PFN_W + 8, PA_W = PFN_W + 12;

  logic clk = 0, rst_n = 0;
  logic [2:0] cmd_op = 0;
  logic [31:0] cmd_index = 0, rand_index = 0;
  logic [VA_W-1:0] stg_hi = 0;
  logic [MW-1:0] stg_mask = 0;
  logic [LO_W-1:0] stg_lo0 = 0, stg_lo1 = 0;
  logic [31:0] probe_index;
  logic [VA_W-1:0] rd_hi;
  logic [MW-1:0] rd_mask;
  logic [LO_W-1:0] rd_lo0, rd_lo1;
  logic xl_req = 0;
  logic [VA_W-1:0] xl_va = 0;
  logic [1:0] xl_type = 0;
  logic [ASID_W-1:0] cur_asid = 0;
  logic xl_valid;
  logic [PA_W-1:0] xl_pa;
  logic [2:0] xl_code, xl_perm;

  int n_tests = 0, n_fail = 0;
  logic [PA_W+5:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  paired_tlb u_paired_tlb (.*);

  function automatic logic [31:0] hi(input logic [31:0] va, input logic [7:0] asid, input logic inv);
    return (va & 32'hFFFF_E000) | (32'(inv) << 10) | 32'(asid);
  endfunction
  function automatic logic [LO_W-1:0] lo(input logic [19:0] pfn, input logic v, input logic d,
                                         input logic g, input logic xi, input logic ri);
    return {ri, xi, pfn, 3'b000, d, v, g};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic stage(input logic [31:0] h, input logic [MW-1:0] m,
                       input logic [LO_W-1:0] l0, input logic [LO_W-1:0] l1);
    @(negedge clk);
    stg_hi = h; stg_mask = m; stg_lo0 = l0; stg_lo1 = l1;
  endtask

  task automatic cmd(input logic [2:0] op, input logic [31:0] idx);
    @(negedge clk);
    cmd_op = op; cmd_index = idx;
    @(negedge clk);
    cmd_op = 0;
  endtask

  task automatic xlate(input string req, input logic [31:0] va, input logic [1:0] ty,
                       input logic [7:0] asid, input logic [PA_W-1:0] pa,
                       input logic [2:0] code, input logic [2:0] perm);
    @(negedge clk);
    xl_va = va; xl_type = ty; cur_asid = asid; xl_req = 1;
    exp_q.push_back({pa, code, perm});
    tag_q.push_back(req);
    @(negedge clk);
    xl_req = 0;
  endtask

  always @(negedge clk) begin
    if (rst_n && xl_valid) begin
      if (exp_q.size() == 0) begin
        n_tests++; n_fail++;
        $display("FAIL R9 actual=unexpected result expected=none");
      end else begin
        chk(tag_q.pop_front(), 64'({xl_pa, xl_code, xl_perm}), 64'(exp_q.pop_front()));
      end
    end
  end

  initial begin
    #400000;
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 probe reg reset", 64'(probe_index), 64'h0);
    chk("R1 read reg reset", 64'(rd_hi), 64'h0);
    xlate("R1 empty nomatch", 32'h0040_0ABC, 0, 5, 0, 1, 0);
    stage(hi(32'h0040_0000, 5, 0), 0, 0, 0);
    cmd(3, 0);
    chk("R1 empty probe miss", 64'(probe_index), 64'h8000_0000);

    // basic pair at slot 2
    stage(hi(32'h0040_0000, 5, 0), 0, lo(20'h12345, 1, 1, 0, 0, 0), lo(20'h23456, 1, 0, 0, 0, 0));
    cmd(1, 2);
    xlate("R7 even load", 32'h0040_0ABC, 0, 5, 32'h1234_5ABC, 0, 3'b111);
    xlate("R8 odd store dirty", 32'h0040_1ABC, 1, 5, 0, 5, 0);
    xlate("R9 odd load perms", 32'h0040_1ABC, 0, 5, 32'h2345_6ABC, 0, 3'b101);
    xlate("R2 asid mismatch", 32'h0040_0ABC, 0, 6, 0, 1, 0);

    // global entry at slot 3, odd half invalid with XI
    stage(hi(32'h0080_0000, 5, 0), 0, lo(20'h00111, 1, 1, 1, 0, 0), lo(20'h00222, 0, 0, 1, 1, 0));
    cmd(1, 3);
    xlate("R2 global any asid", 32'h0080_0010, 0, 8'h33, 32'h0011_1010, 0, 3'b111);
    xlate("R8 invalid before xi", 32'h0080_1010, 2, 5, 0, 2, 0);

    // inhibit bits at slot 4
    stage(hi(32'h00C0_0000, 5, 0), 0, lo(20'h00444, 1, 1, 0, 1, 1), lo(20'h00555, 1, 0, 0, 0, 1));
    cmd(1, 4);
    xlate("R8 fetch xi", 32'h00C0_0004, 2, 5, 0, 3, 0);
    xlate("R8 load ri", 32'h00C0_0004, 0, 5, 0, 4, 0);
    xlate("R9 store no exec", 32'h00C0_0004, 1, 5, 32'h0044_4004, 0, 3'b011);
    xlate("R8 store dirty odd", 32'h00C0_1004, 1, 5, 0, 5, 0);
    xlate("R9 fetch read exec", 32'h00C0_1004, 2, 5, 32'h0055_5004, 0, 3'b101);

    // larger page pair at slot 5
    stage(hi(32'h0100_0000, 5, 0), 19'h3, lo(20'h00ABF, 1, 1, 0, 0, 0), lo(20'h00DE0, 1, 1, 0, 0, 0));
    cmd(1, 5);
    xlate("R7 masked even", 32'h0100_3123, 0, 5, 32'h00AB_F123, 0, 3'b111);
    xlate("R7 masked odd", 32'h0100_7123, 0, 5, 32'h00DE_3123, 0, 3'b111);
    cmd(4, 5);
    chk("R12 read hi", 64'(rd_hi), 64'h0100_0005);
    chk("R12 read mask", 64'(rd_mask), 64'h3);
    chk("R3 pfn masked lo0", 64'(rd_lo0), 64'(lo(20'h00ABC, 1, 1, 0, 0, 0)));
    chk("R12 read lo1", 64'(rd_lo1), 64'(lo(20'h00DE0, 1, 1, 0, 0, 0)));
    cmd(4, 3);
    chk("R12 global lo0", 64'(rd_lo0), 64'(lo(20'h00111, 1, 1, 1, 0, 0)));
    chk("R12 global lo1", 64'(rd_lo1), 64'(lo(20'h00222, 0, 0, 1, 1, 0)));

    // modulo index and global AND
    stage(hi(32'h0140_0000, 5, 0), 0, lo(20'h00777, 1, 1, 1, 0, 0), lo(20'h00888, 1, 1, 0, 0, 0));
    cmd(1, 32'h8000_000F);
    xlate("R3 g needs both", 32'h0140_0000, 0, 6, 0, 1, 0);
    cmd(4, 32'h0000_0007);
    chk("R4 modulo slot", 64'(rd_lo0), 64'(lo(20'h00777, 1, 1, 0, 0, 0)));

    // probe
    stage(hi(32'h0040_0000, 5, 0), 0, lo(20'h66666, 1, 1, 0, 0, 0), 0);
    cmd(3, 0);
    chk("R5 probe hit", 64'(probe_index), 64'h2);
    cmd(1, 6);
    cmd(3, 0);
    chk("R5 lowest index", 64'(probe_index), 64'h2);
    xlate("R7 lowest wins", 32'h0040_0ABC, 0, 5, 32'h1234_5ABC, 0, 3'b111);
    stage(hi(32'h0040_0000, 7, 0), 0, 0, 0);
    cmd(3, 0);
    chk("R5 probe miss", 64'(probe_index), 64'h8000_0000);
    stage(hi(32'h0080_0000, 8'h7F, 0), 0, 0, 0);
    cmd(3, 0);
    chk("R5 probe global", 64'(probe_index), 64'h3);

    // random write
    stage(hi(32'h0200_0000, 5, 0), 0, lo(20'h00AAA, 1, 1, 0, 0, 0), 0);
    @(negedge clk); rand_index = 32'h0000_0009;
    cmd(2, 0);
    cmd(3, 0);
    chk("R4 random slot", 64'(probe_index), 64'h1);

    // invalidating write
    stage(hi(32'h0900_0000, 5, 1), 19'h7, lo(20'hFFFFF, 1, 1, 1, 0, 0), lo(20'h1, 1, 1, 1, 0, 0));
    cmd(1, 2);
    xlate("R6 next copy visible", 32'h0040_0ABC, 0, 5, 32'h6666_6ABC, 0, 3'b111);
    cmd(4, 2);
    chk("R6 inv read hi", 64'(rd_hi), 64'h400);
    chk("R6 inv read rest", 64'({rd_mask, rd_lo0, rd_lo1}), 64'h0);

    // selective invalidate
    stage(hi(32'h0300_0000, 9, 0), 0, lo(20'h00BBB, 1, 1, 0, 0, 0), 0);
    cmd(1, 0);
    stage(hi(32'h0, 5, 0), 0, 0, 0);
    cmd(5, 0);
    xlate("R10 asid removed", 32'h0040_0ABC, 0, 5, 0, 1, 0);
    xlate("R10 global kept", 32'h0080_0010, 0, 5, 32'h0011_1010, 0, 3'b111);
    xlate("R10 other asid kept", 32'h0300_0000, 0, 9, 32'h00BB_B000, 0, 3'b111);

    // full invalidate
    cmd(6, 0);
    xlate("R11 global removed", 32'h0080_0010, 0, 5, 0, 1, 0);
    stage(hi(32'h0080_0000, 5, 0), 0, 0, 0);
    cmd(3, 0);
    chk("R11 probe miss", 64'(probe_index), 64'h8000_0000);
    cmd(4, 3);
    chk("R11 read invalid", 64'(rd_hi), 64'h400);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_tests++; n_fail++;
      $display("FAIL R9 actual=%0d pending expected=0", exp_q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule